// File: doc/BRIEF.md
# Manchester Receive Decoder with Carrier Sense

This block turns a single-bit Manchester-coded serial stream into NRZ data with a recovered bit clock. The stream arrives already sliced to logic level and is sampled by a local clock running at eight times the bit rate (80 MHz for a 10 Mb/s line). A single saturating counter tracks how many samples have passed since the last accepted mid-bit transition. That counter sets the acceptance window for the next data transition, the phase of the recovered clock, and the hold-off times that end carrier sense and stop the clock after activity ends.

A loopback input swaps the line input for the locally encoded transmit stream. A separate collision-activity input drives a collision flag that is raised while that input toggles at roughly the bit rate. All outputs are registered. Reset is synchronous and active high.

Top module: `mrx_decoder`

## Requirements
- R1: With `loopback` = 1 the decoder follows `tx_loop` and activity on `rx_line` has no effect on any receive output. With `loopback` = 0 the roles are swapped.
- R2: In the hunting state the first transition seen is taken as a mid-bit edge. After that, a transition arriving fewer than 6 samples after the last accepted edge is a cell-boundary edge and is ignored. A transition arriving 6 to 10 samples after it is accepted.
- R3: `rx_data` takes the line level that follows each accepted mid-bit edge, so a low-to-high mid-bit transition decodes as 1. The update appears on the second sample-clock edge after the transition is presented at the input.
- R4: A second accepted edge within the window locks the decoder, and `crs` is 1 from that point.
- R5: When 10 samples pass with no accepted edge, lock is lost. `crs` falls when 16 samples (two bit times) have passed since the last accepted edge, which is 1.5 bit times after the end of the last bit.
- R6: The sample counter runs 1, 2, 3 and so on after each accepted edge. While the clock is enabled, `rx_clk` is high when that count modulo 8 is 4 to 7 and low otherwise, so its rising edge falls mid-way through each NRZ bit. `rx_clk` stays low until the first lock.
- R7: After lock, `rx_clk` keeps running until 40 samples (5 bit times) pass without an accepted edge. From then on it is held low.
- R8: `col` rises on a collision-input transition that comes fewer than 8 samples after the previous one. It falls once 8 samples pass with no transition.
- R9: During and right after reset, `rx_clk`, `rx_data`, `crs` and `col` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, 8x the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Manchester-coded line input |
| tx_loop | input | 1 | Local transmit stream, decoded in loopback |
| loopback | input | 1 | 1 selects `tx_loop` as the decoder input |
| col_line | input | 1 | Collision activity input |
| rx_clk | output | 1 | Recovered receive clock |
| rx_data | output | 1 | NRZ receive data |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision indication |

## Verification
The assertions assume that every input changes at most once per sample clock and is held at least one full sample. Under that assumption a transition seen by the two-stage input register is a real line transition and never a glitch between samples. The stimulus drives every input on the falling edge of the sample clock. It builds Manchester cells from half-cells of 3 to 5 samples, which keeps the spacing between mid-bit edges within 6 to 10 samples and the spacing to boundary edges below 6. Out-of-window spacing is used only on purpose, to force loss of lock.

// File: rtl/mrx_pkg.sv
`timescale 1ns/1ps
package mrx_pkg;
  typedef enum logic [1:0] {
    TRK_HUNT   = 2'd0,
    TRK_ARMED  = 2'd1,
    TRK_LOCKED = 2'd2
  } trk_state_e;
endpackage

// File: rtl/mrx_edge_det.sv
`timescale 1ns/1ps
// Input register chain; exposes the newest two registered samples.
module mrx_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  output logic [1:0] tap
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  // tap[1] = newer sample, tap[0] = older sample
  assign tap = {chain[STAGES-2], chain[STAGES-1]};
endmodule

// File: rtl/mrx_bit_tracker.sv
`timescale 1ns/1ps
module mrx_bit_tracker
  import mrx_pkg::*;
#(
  parameter int unsigned WIN_LO  = 6,
  parameter int unsigned WIN_HI  = 10,
  parameter int unsigned CNT_MAX = 40,
  parameter int unsigned CW      = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    tap,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d,
  output trk_state_e    state_q,
  output logic          lock_d,
  output logic          data_q
);
  localparam logic [CW-1:0] LO_C  = CW'(WIN_LO);
  localparam logic [CW-1:0] HI_C  = CW'(WIN_HI);
  localparam logic [CW-1:0] MAX_C = CW'(CNT_MAX);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  trk_state_e state_d;
  logic       data_d;
  logic       edge_p;
  logic       in_win;

  assign edge_p = tap[1] ^ tap[0];
  assign in_win = (cnt_q >= LO_C) && (cnt_q <= HI_C);

  always_comb begin
    cnt_d   = cnt_q;
    state_d = state_q;
    data_d  = data_q;
    if (edge_p && state_q == TRK_HUNT) begin
      cnt_d   = ONE_C;
      state_d = TRK_ARMED;
      data_d  = tap[1];
    end else if (edge_p && in_win) begin
      cnt_d   = ONE_C;
      state_d = TRK_LOCKED;
      data_d  = tap[1];
    end else begin
      if (cnt_q != MAX_C) cnt_d = cnt_q + ONE_C;
      if (state_q != TRK_HUNT && cnt_q >= HI_C) state_d = TRK_HUNT;
    end
  end

  assign lock_d = (state_d == TRK_LOCKED);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= MAX_C;
      state_q <= TRK_HUNT;
      data_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      state_q <= state_d;
      data_q  <= data_d;
    end
  end

  AST_EARLY_EDGE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (edge_p && state_q != TRK_HUNT && cnt_q < LO_C) |=> (data_q == $past(data_q)) && (cnt_q == $past(cnt_q) + ONE_C)); // R2
  AST_LOCK_FROM_ARMED: assert property (@(posedge clk) disable iff (rst)
    (state_q == TRK_LOCKED && $past(state_q) != TRK_LOCKED) |-> ($past(state_q) == TRK_ARMED)); // R4
  AST_TRACK_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (state_q != TRK_HUNT) |-> (cnt_q <= HI_C)); // R5
  AST_DATA_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    (data_q != $past(data_q)) |-> $past(edge_p)); // R3
endmodule

// File: rtl/mrx_link_status.sv
`timescale 1ns/1ps
module mrx_link_status #(
  parameter int unsigned OSR      = 8,
  parameter int unsigned CRS_HOLD = 16,
  parameter int unsigned CNT_MAX  = 40,
  parameter int unsigned CW       = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_d,
  input  logic          lock_d,
  output logic          crs,
  output logic          rx_clk
);
  localparam int unsigned PW     = $clog2(OSR);
  localparam logic [CW-1:0] HOLD_C = CW'(CRS_HOLD);
  localparam logic [CW-1:0] MAX_C  = CW'(CNT_MAX);

  logic en_q, en_d, half;

  generate
    if ((OSR & (OSR - 1)) == 0) begin : g_pow2
      assign half = cnt_d[PW-1];
    end else begin : g_mod
      assign half = (cnt_d % CW'(OSR)) >= CW'(OSR / 2);
    end
  endgenerate

  assign en_d = lock_d | (en_q & (cnt_d < MAX_C));

  always_ff @(posedge clk) begin
    if (rst) begin
      crs    <= 1'b0;
      en_q   <= 1'b0;
      rx_clk <= 1'b0;
    end else begin
      crs    <= lock_d | (crs & (cnt_d < HOLD_C));
      en_q   <= en_d;
      rx_clk <= en_d & half;
    end
  end

  AST_CLK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_clk) |-> en_q); // R6
endmodule

// File: rtl/mrx_col_detect.sv
`timescale 1ns/1ps
module mrx_col_detect #(
  parameter int unsigned OSR = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] tap,
  output logic       col
);
  localparam int unsigned GW = $clog2(OSR + 1);
  localparam logic [GW-1:0] FULL_C = GW'(OSR);
  localparam logic [GW-1:0] NEAR_C = GW'(OSR - 1);
  localparam logic [GW-1:0] ONE_C  = GW'(1);

  logic [GW-1:0] gap;
  logic          cedge;

  assign cedge = tap[1] ^ tap[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= FULL_C;
      col <= 1'b0;
    end else if (cedge) begin
      if (gap < FULL_C) col <= 1'b1;
      gap <= ONE_C;
    end else begin
      if (gap >= NEAR_C) col <= 1'b0;
      if (gap != FULL_C) gap <= gap + ONE_C;
    end
  end

  AST_COL_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(col) |-> $past(cedge)); // R8
  AST_COL_QUIET_LOW: assert property (@(posedge clk) disable iff (rst)
    (gap == FULL_C) |-> !col); // R8
endmodule

// File: rtl/mrx_decoder.sv
`timescale 1ns/1ps
module mrx_decoder
  import mrx_pkg::*;
#(
  parameter int unsigned OSR         = 8,
  parameter int unsigned WIN_LO      = 6,
  parameter int unsigned WIN_HI      = 10,
  parameter int unsigned IDLE_BITS   = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_line,
  input  logic tx_loop,
  input  logic loopback,
  input  logic col_line,
  output logic rx_clk,
  output logic rx_data,
  output logic crs,
  output logic col
);
  localparam int unsigned CRS_HOLD = 2 * OSR;
  localparam int unsigned CNT_MAX  = IDLE_BITS * OSR;
  localparam int unsigned CW       = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(CRS_HOLD);
  localparam logic [CW-1:0] MAX_C  = CW'(CNT_MAX);

  logic          line_sel;
  logic [1:0]    rx_tap, col_tap;
  logic [CW-1:0] cnt_q, cnt_d;
  trk_state_e    state_q;
  logic          lock_d;

  assign line_sel = loopback ? tx_loop : rx_line;

  mrx_edge_det #(.STAGES(SYNC_STAGES)) u_rx_sync (
    .clk(clk), .rst(rst), .din(line_sel), .tap(rx_tap));

  mrx_edge_det #(.STAGES(SYNC_STAGES)) u_col_sync (
    .clk(clk), .rst(rst), .din(col_line), .tap(col_tap));

  mrx_bit_tracker #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .CNT_MAX(CNT_MAX), .CW(CW)) u_track (
    .clk(clk), .rst(rst), .tap(rx_tap), .cnt_q(cnt_q), .cnt_d(cnt_d),
    .state_q(state_q), .lock_d(lock_d), .data_q(rx_data));

  mrx_link_status #(.OSR(OSR), .CRS_HOLD(CRS_HOLD), .CNT_MAX(CNT_MAX), .CW(CW)) u_link (
    .clk(clk), .rst(rst), .cnt_d(cnt_d), .lock_d(lock_d), .crs(crs), .rx_clk(rx_clk));

  mrx_col_detect #(.OSR(OSR)) u_col (
    .clk(clk), .rst(rst), .tap(col_tap), .col(col));

  AST_CRS_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
    $fell(crs) |-> (cnt_q == HOLD_C)); // R5
  AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == MAX_C) |-> !rx_clk); // R7
  AST_CRS_WHEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (state_q == TRK_LOCKED) |-> crs); // R4
endmodule

// File: tb/sim_mrx_decoder.sv
`timescale 1ns/1ps
module sim_mrx_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_line = 1'b0, tx_loop = 1'b0, loopback = 1'b0, col_line = 1'b0;
  logic rx_clk, rx_data, crs, col;

  int vectors = 0;
  int errors  = 0;
  bit live = 0;
  bit done = 0;
  bit tgt_tx = 0;
  string phase = "R9";

  // behavioural reference state
  int m_a = 0, m_b = 0, m_cnt = 40, m_mode = 0, m_data = 0;
  int m_crs = 0, m_en = 0, m_clk = 0;
  int c_a = 0, c_b = 0, c_gap = 8, m_col = 0;
  int in_now = 0;

  always #4 clk = ~clk;  // 125 MHz

  mrx_decoder u0 (
    .clk(clk), .rst(rst), .rx_line(rx_line), .tx_loop(tx_loop),
    .loopback(loopback), .col_line(col_line),
    .rx_clk(rx_clk), .rx_data(rx_data), .crs(crs), .col(col));

  always @(posedge clk) begin
    live <= 1'b1;
    if (rst) begin
      m_a = 0; m_b = 0; m_cnt = 40; m_mode = 0; m_data = 0;
      m_crs = 0; m_en = 0; m_clk = 0;
      c_a = 0; c_b = 0; c_gap = 8; m_col = 0;
    end else begin
      in_now = loopback ? int'(tx_loop) : int'(rx_line);
      if (m_a != m_b && m_mode == 0) begin
        m_cnt = 1; m_mode = 1; m_data = m_a;
      end else if (m_a != m_b && m_cnt >= 6 && m_cnt <= 10) begin
        m_cnt = 1; m_mode = 2; m_data = m_a;
      end else begin
        if (m_mode != 0 && m_cnt >= 10) m_mode = 0;
        if (m_cnt < 40) m_cnt++;
      end
      m_crs = (m_mode == 2 || (m_crs == 1 && m_cnt < 16)) ? 1 : 0;
      m_en  = (m_mode == 2 || (m_en == 1 && m_cnt < 40)) ? 1 : 0;
      m_clk = (m_en == 1 && (m_cnt % 8) >= 4) ? 1 : 0;
      m_b = m_a; m_a = in_now;
      if (c_a != c_b) begin
        if (c_gap < 8) m_col = 1;
        c_gap = 1;
      end else begin
        if (c_gap >= 7) m_col = 0;
        if (c_gap < 8) c_gap++;
      end
      c_b = c_a; c_a = int'(col_line);
    end
  end

  task automatic cmp(input string what, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", what, phase, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      cmp("R3 rx_data", int'(rx_data), m_data);
      cmp("R4/R5 crs", int'(crs), m_crs);
      cmp("R6/R7 rx_clk", int'(rx_clk), m_clk);
      cmp("R8 col", int'(col), m_col);
    end
  end

  task automatic put(input bit v, input int n);
    repeat (n) begin
      if (tgt_tx) tx_loop = v; else rx_line = v;
      @(negedge clk);
    end
  endtask

  task automatic mbit(input bit v, input int h1, input int h2);
    put(!v, h1);
    put(v, h2);
  endtask

  task automatic frame(input int nb, input logic [31:0] pat, input bit jit, input int gap_at);
    int k;
    k = 0;
    for (int i = 0; i < 8 + nb; i++) begin
      bit v;
      v = (i < 8) ? ((i % 2) == 0) : pat[i-8];
      if (i == gap_at) put(!v, 10);
      if (jit) mbit(v, 3 + (k % 3), 3 + ((2 * k + 1) % 3));
      else     mbit(v, 4, 4);
      k++;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    phase = "R9";
    cmp("R9 reset outputs", int'({rx_clk, rx_data, crs, col}), 0);
    rst = 1'b0;
    @(negedge clk);
    cmp("R9 after reset outputs", int'({rx_clk, rx_data, crs, col}), 0);

    // clean frame on the line, with a mid-frame lock and clock check
    phase = "R3 clean";
    tgt_tx = 0;
    fork
      frame(24, 32'h00A5_3C96, 0, -1);
      begin
        int rises;
        bit prev;
        repeat (100) @(negedge clk);
        cmp("R4 crs locked mid-frame", int'(crs), 1);
        rises = 0; prev = rx_clk;
        repeat (80) begin
          @(negedge clk);
          if (rx_clk && !prev) rises++;
          prev = rx_clk;
        end
        cmp("R6 rx_clk rises in 10 bits", rises, 10);
      end
    join
    put(0, 20);
    cmp("R7 rx_clk still running before 5 bit idle", int'(m_en), 1);
    put(0, 50);
    cmp("R5 crs low after idle", int'(crs), 0);
    cmp("R7 rx_clk held low after idle", int'(rx_clk), 0);

    // jittered cells: boundary edges must be ignored
    phase = "R2 jitter";
    frame(20, 32'h0003_B2E1, 1, -1);
    put(0, 70);

    // gap inside a frame forces loss of lock and reacquisition
    phase = "R5 gap";
    frame(16, 32'h0000_6D4B, 0, 14);
    put(0, 70);

    // loopback: decode tx_loop while rx_line toggles
    phase = "R1 loopback";
    loopback = 1'b1;
    tgt_tx = 1;
    fork
      frame(16, 32'h0000_5AC3, 0, -1);
      repeat (50) begin rx_line = ~rx_line; repeat (4) @(negedge clk); end
    join
    put(0, 70);
    repeat (12) begin rx_line = ~rx_line; repeat (4) @(negedge clk); end
    cmp("R1 rx_line ignored in loopback crs", int'(crs), 0);
    cmp("R1 rx_line ignored in loopback rx_clk", int'(rx_clk), 0);
    rx_line = 1'b0;
    put(0, 4);
    loopback = 1'b0;
    tgt_tx = 0;
    repeat (12) begin tx_loop = ~tx_loop; repeat (4) @(negedge clk); end
    cmp("R1 tx_loop ignored without loopback", int'(crs), 0);
    tx_loop = 1'b0;
    put(0, 60);

    // collision activity
    phase = "R8 col";
    repeat (8) begin col_line = ~col_line; repeat (4) @(negedge clk); end
    cmp("R8 col raised by 10 MHz activity", int'(col), 1);
    repeat (20) @(negedge clk);
    cmp("R8 col cleared after quiet bit", int'(col), 0);
    repeat (5) begin col_line = ~col_line; repeat (9) @(negedge clk); end
    cmp("R8 col stays low for slow toggles", int'(col), 0);
    repeat (4) begin col_line = ~col_line; repeat (7) @(negedge clk); end
    cmp("R8 col raised by 7-sample spacing", int'(col), 1);
    repeat (20) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL all watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule